// File: doc/BRIEF.md
# Partitioned XOR Cell-Array Sequencer

This block is a cycle-accurate behavioural model of a three-cell logic-in-memory array together with the controller that sequences it. It evaluates the exclusive-OR of two operand bits by cofactor partitioning. The two cofactors of the second operand are preloaded into two storage cells. The first operand then only decides which of those cells is frozen ("clocked"). The cell left free drives the third, output cell.

An operation starts on a one-cycle start strobe, which also samples both operands. The controller steps through four ordered phases: write, clock, settle and release. The write, clock and settle phases each last a parameterised number of cycles, and the release phase lasts one cycle. The per-cell write, clock and release strobes are brought out so the sequence can be observed. A one-cycle done pulse marks the release cycle. The result output shows the output cell's stored value.

Top module: `xor_partition_seq`

## Requirements
- R1: While rst_ni is low, result_o, done_o and every bit of cell_wr_o, cell_clk_o and cell_rel_o are 0; all three cells are cleared and unclocked, and the controller is idle.
- R2: On the last write-phase cycle, cell_wr_o is 3'b011 (bit 0 = cofactor cell A, bit 1 = cofactor cell B, bit 2 = output cell). Cell A then stores the sampled x2 and cell B stores its complement; no write strobe appears on earlier write cycles.
- R3: On the first clock-phase cycle, cell_clk_o is 3'b100 (output cell). On the last clock-phase cycle, cell_clk_o is 3'b001 when the sampled x1 is 1 and 3'b010 when it is 0. At most one cofactor cell is ever clocked, and only while the output cell is clocked.
- R4: On the first settle cycle, cell_rel_o is 3'b100. On the last settle cycle, cell_wr_o is 3'b100, and the output cell is loaded from the unclocked cofactor cell (B when x1 is 1, A when x1 is 0).
- R5: The release phase lasts exactly one cycle. In it, cell_rel_o releases the cofactor cell clocked earlier (3'b001 when x1 is 1, 3'b010 when x1 is 0), and done_o is high for that cycle only.
- R6: done_o rises WRITE_CYC+CLOCK_CYC+SETTLE_CYC cycles after the clock edge that accepts start_i, and it is low on every earlier cycle of the operation.
- R7: From the release cycle until the next operation's settle phase ends, result_o equals x1 XOR x2 of the accepted operands.
- R8: A start_i that arrives while an operation is in progress (any phase other than idle) is ignored. It changes neither the operands nor the timing.
- R9: A clocked cell keeps its stored value until it is released. A write strobe to a clocked cell without a release in the same cycle has no effect. result_o therefore keeps the previous result through the clock and settle phases.
- R10: The operands are sampled only on the accepting edge. Changing x1_i or x2_i afterwards has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, samples operands when idle |
| x1_i | input | 1 | Operand selecting which cofactor cell is clocked |
| x2_i | input | 1 | Operand whose cofactors are preloaded |
| result_o | output | 1 | Output cell stored value |
| done_o | output | 1 | One-cycle pulse in the release cycle |
| cell_wr_o | output | 3 | Per-cell write strobes (bit 0 A, bit 1 B, bit 2 output) |
| cell_clk_o | output | 3 | Per-cell clock strobes |
| cell_rel_o | output | 3 | Per-cell release strobes |

## Verification
The assertions check the following on every cycle:
- the single-clocked-cofactor rule and the requirement that the output cell is clocked first;
- that a clocked cell keeps its value;
- the cofactor contents after a write;
- that done is a single-cycle pulse carrying the XOR of the latched operands;
- that operands stay frozen under a late start.

Only the bench scenarios can show the exact cycle on which each strobe appears, the overall latency, and the result holding over into the next operation. They also show that operand changes after the start are ignored and that an asynchronous reset in mid-operation is recovered from.

// File: rtl/xor_pkg.sv
package xor_pkg;
  localparam int unsigned NCELL = 3;
  localparam int unsigned CELL_A = 0;
  localparam int unsigned CELL_B = 1;
  localparam int unsigned CELL_O = 2;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_WRITE  = 3'd1,
    PH_CLOCK  = 3'd2,
    PH_SETTLE = 3'd3,
    PH_REL    = 3'd4
  } phase_e;
endpackage

// File: rtl/xor_mem_cell.sv
module xor_mem_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wdata_i,
  input  logic clk_stb_i,
  input  logic rel_i,
  output logic val_o,
  output logic clkd_o
);
  logic val_q, clkd_q;
  // write allowed when unclocked or released in the same cycle
  logic wr_ok;
  assign wr_ok = wr_i && (!clkd_q || rel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q  <= 1'b0;
      clkd_q <= 1'b0;
    end else begin
      if (wr_ok) val_q <= wdata_i;
      if (rel_i) clkd_q <= 1'b0;
      else if (clk_stb_i) clkd_q <= 1'b1;
    end
  end

  assign val_o  = val_q;
  assign clkd_o = clkd_q;
endmodule

// File: rtl/xor_phase_ctrl.sv
module xor_phase_ctrl
  import xor_pkg::*;
#(
  parameter int unsigned WRITE_CYC  = 2,
  parameter int unsigned CLOCK_CYC  = 3,
  parameter int unsigned SETTLE_CYC = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  output phase_e phase_o,
  output logic   first_o,
  output logic   last_o,
  output logic   accept_o
);
  localparam int unsigned MAX_A = (WRITE_CYC > CLOCK_CYC) ? WRITE_CYC : CLOCK_CYC;
  localparam int unsigned MAX_D = (MAX_A > SETTLE_CYC) ? MAX_A : SETTLE_CYC;
  localparam int unsigned CNT_W = (MAX_D < 2) ? 1 : $clog2(MAX_D);

  phase_e phase_q;
  logic [CNT_W-1:0] cnt_q, lim;

  always_comb begin
    unique case (phase_q)
      PH_WRITE:  lim = CNT_W'(WRITE_CYC - 1);
      PH_CLOCK:  lim = CNT_W'(CLOCK_CYC - 1);
      PH_SETTLE: lim = CNT_W'(SETTLE_CYC - 1);
      default:   lim = '0;
    endcase
  end

  assign first_o  = (cnt_q == '0);
  assign last_o   = (cnt_q == lim);
  assign accept_o = start_i && (phase_q == PH_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (phase_q == PH_IDLE) begin
      cnt_q <= '0;
      if (start_i) phase_q <= PH_WRITE;
    end else if (last_o) begin
      cnt_q <= '0;
      unique case (phase_q)
        PH_WRITE:  phase_q <= PH_CLOCK;
        PH_CLOCK:  phase_q <= PH_SETTLE;
        PH_SETTLE: phase_q <= PH_REL;
        default:   phase_q <= PH_IDLE;
      endcase
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/xor_strobe_dec.sv
module xor_strobe_dec
  import xor_pkg::*;
(
  input  phase_e           phase_i,
  input  logic             first_i,
  input  logic             last_i,
  input  logic             sel_i,
  input  logic             x2_i,
  input  logic [1:0]       cof_val_i,
  output logic [NCELL-1:0] wr_o,
  output logic [NCELL-1:0] wdata_o,
  output logic [NCELL-1:0] clk_o,
  output logic [NCELL-1:0] rel_o
);
  // sel_i=1 freezes cell A, so B is the driver; sel_i=0 the reverse
  logic [NCELL-1:0] cof_pick;
  assign cof_pick = sel_i ? NCELL'(1 << CELL_A) : NCELL'(1 << CELL_B);

  always_comb begin
    wr_o    = '0;
    wdata_o = '0;
    clk_o   = '0;
    rel_o   = '0;
    unique case (phase_i)
      PH_WRITE: if (last_i) begin
        wr_o[CELL_A]    = 1'b1;
        wr_o[CELL_B]    = 1'b1;
        wdata_o[CELL_A] = x2_i;
        wdata_o[CELL_B] = ~x2_i;
      end
      PH_CLOCK: begin
        if (first_i) clk_o[CELL_O] = 1'b1;
        if (last_i)  clk_o = clk_o | cof_pick;
      end
      PH_SETTLE: begin
        if (first_i) rel_o[CELL_O] = 1'b1;
        if (last_i) begin
          wr_o[CELL_O]    = 1'b1;
          wdata_o[CELL_O] = sel_i ? cof_val_i[CELL_B] : cof_val_i[CELL_A];
        end
      end
      PH_REL:  rel_o = cof_pick;
      default: ;
    endcase
  end
endmodule

// File: rtl/xor_partition_seq.sv
module xor_partition_seq
  import xor_pkg::*;
#(
  parameter int unsigned WRITE_CYC  = 2,
  parameter int unsigned CLOCK_CYC  = 3,
  parameter int unsigned SETTLE_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       x1_i,
  input  logic       x2_i,
  output logic       result_o,
  output logic       done_o,
  output logic [2:0] cell_wr_o,
  output logic [2:0] cell_clk_o,
  output logic [2:0] cell_rel_o
);
  phase_e phase_q;
  logic first, last, accept;
  logic op_x1_q, op_x2_q;
  logic [NCELL-1:0] wr, wdata, cstb, rel, cell_val, cell_clkd;

  xor_phase_ctrl #(
    .WRITE_CYC (WRITE_CYC),
    .CLOCK_CYC (CLOCK_CYC),
    .SETTLE_CYC(SETTLE_CYC)
  ) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .phase_o (phase_q),
    .first_o (first),
    .last_o  (last),
    .accept_o(accept)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_x1_q <= 1'b0;
      op_x2_q <= 1'b0;
    end else if (accept) begin
      op_x1_q <= x1_i;
      op_x2_q <= x2_i;
    end
  end

  xor_strobe_dec u_dec (
    .phase_i  (phase_q),
    .first_i  (first),
    .last_i   (last),
    .sel_i    (op_x1_q),
    .x2_i     (op_x2_q),
    .cof_val_i(cell_val[1:0]),
    .wr_o     (wr),
    .wdata_o  (wdata),
    .clk_o    (cstb),
    .rel_o    (rel)
  );

  for (genvar g = 0; g < NCELL; g++) begin : g_cell
    xor_mem_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (wr[g]),
      .wdata_i  (wdata[g]),
      .clk_stb_i(cstb[g]),
      .rel_i    (rel[g]),
      .val_o    (cell_val[g]),
      .clkd_o   (cell_clkd[g])
    );
  end

  assign result_o   = cell_val[CELL_O];
  assign done_o     = (phase_q == PH_REL);
  assign cell_wr_o  = wr;
  assign cell_clk_o = cstb;
  assign cell_rel_o = rel;
endmodule

// File: rtl/xor_partition_seq_chk.sv
module xor_partition_seq_chk
  import xor_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       result_o,
  input logic       done_o,
  input logic [2:0] cell_wr_o,
  input logic [2:0] cell_clk_o,
  input logic [2:0] cell_rel_o,
  input phase_e     phase_q,
  input logic [2:0] cell_val,
  input logic [2:0] cell_clkd,
  input logic       op_x1_q,
  input logic       op_x2_q
);
  AST_ONE_COF_CLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cell_clkd[1:0]) <= 1); // R3
  AST_OUT_CLOCKED_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cell_clk_o[1:0]) |-> (cell_clkd[2] || cell_clk_o[2])); // R3
  AST_COF_LOADED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_wr_o[0] && !cell_clkd[0]) |=> (cell_val[0] == op_x2_q && cell_val[1] == !op_x2_q)); // R2
  AST_HOLD_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_clkd[0] && !cell_rel_o[0]) |=> $stable(cell_val[0])); // R9
  AST_HOLD_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_clkd[1] && !cell_rel_o[1]) |=> $stable(cell_val[1])); // R9
  AST_HOLD_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_clkd[2] && !cell_rel_o[2]) |=> $stable(cell_val[2])); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
  AST_DONE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (result_o == (op_x1_q ^ op_x2_q))); // R7
  AST_LATE_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && phase_q != PH_IDLE) |=> ($stable(op_x1_q) && $stable(op_x2_q))); // R8
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (cell_wr_o == 3'b000 && cell_clk_o == 3'b000 && !done_o)); // R1
endmodule

bind xor_partition_seq xor_partition_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .result_o  (result_o),
  .done_o    (done_o),
  .cell_wr_o (cell_wr_o),
  .cell_clk_o(cell_clk_o),
  .cell_rel_o(cell_rel_o),
  .phase_q   (phase_q),
  .cell_val  (cell_val),
  .cell_clkd (cell_clkd),
  .op_x1_q   (op_x1_q),
  .op_x2_q   (op_x2_q)
);

// File: tb/xor_partition_seq_tb_top.sv
module xor_partition_seq_tb_top;
  localparam int W = 2;
  localparam int C = 3;
  localparam int S = 2;
  localparam int L = W + C + S;
  localparam int NVEC = 5;
  // {x1, x2, expected}
  localparam logic [2:0] VEC [NVEC] = '{3'b000, 3'b011, 3'b101, 3'b110, 3'b011};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, x1_i = 1'b0, x2_i = 1'b0;
  logic result_o, done_o;
  logic [2:0] cell_wr_o, cell_clk_o, cell_rel_o;
  int checks = 0, errs = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  xor_partition_seq #(.WRITE_CYC(W), .CLOCK_CYC(C), .SETTLE_CYC(S)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .x1_i(x1_i), .x2_i(x2_i),
    .result_o(result_o), .done_o(done_o), .cell_wr_o(cell_wr_o),
    .cell_clk_o(cell_clk_o), .cell_rel_o(cell_rel_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_op(input logic x1, input logic x2, input logic exp, input logic prev);
    logic [2:0] cof;
    cof = x1 ? 3'b001 : 3'b010;
    @(negedge clk);
    start_i = 1'b1; x1_i = x1; x2_i = x2;
    @(negedge clk);
    start_i = 1'b0; x1_i = ~x1; x2_i = ~x2; // R10: late operand change
    for (int k = 0; k <= L + 1; k++) begin
      if (k == 0) chk(cell_wr_o == 3'b000, "R2 early write", cell_wr_o, 0);
      if (k == W - 1) chk(cell_wr_o == 3'b011, "R2 cofactor write", cell_wr_o, 3);
      if (k == W) chk(cell_clk_o == 3'b100, "R3 output clock", cell_clk_o, 4);
      if (k == W + C - 1) chk(cell_clk_o == cof, "R3 cofactor clock", cell_clk_o, cof);
      if (k == W + C) begin
        chk(cell_rel_o == 3'b100, "R4 output release", cell_rel_o, 4);
        chk(result_o == prev, "R9 hold prev", result_o, prev);
      end
      if (k == W + C + S - 1) begin
        chk(cell_wr_o == 3'b100, "R4 output write", cell_wr_o, 4);
        chk(result_o == prev, "R9 hold prev", result_o, prev);
      end
      if (k < L) chk(done_o == 1'b0, "R6 early done", done_o, 0);
      if (k == L) begin
        chk(done_o == 1'b1, "R6 latency", done_o, 1);
        chk(result_o == exp, "R7 R10 result", result_o, exp);
        chk(cell_rel_o == cof, "R5 cofactor release", cell_rel_o, cof);
      end
      if (k == L + 1) begin
        chk(done_o == 1'b0, "R5 single pulse", done_o, 0);
        chk(result_o == exp, "R7 held", result_o, exp);
        chk(cell_wr_o == 3'b000, "R8 no restart", cell_wr_o, 0);
      end
      if (k == 3) begin start_i = 1'b1; x1_i = ~x1; x2_i = x2; end // R8
      if (k == 4) start_i = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    logic prev;
    @(negedge clk);
    chk(result_o == 1'b0 && done_o == 1'b0, "R1 reset outputs", {result_o, done_o}, 0);
    chk(cell_wr_o == 0 && cell_clk_o == 0 && cell_rel_o == 0, "R1 reset strobes",
        {cell_wr_o, cell_clk_o, cell_rel_o}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    prev = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      chk(VEC[i][0] == (VEC[i][2] ^ VEC[i][1]), "R7 table", VEC[i][0], VEC[i][2] ^ VEC[i][1]);
      run_op(VEC[i][2], VEC[i][1], VEC[i][0], prev);
      prev = VEC[i][0];
    end
    // reset in mid-operation
    @(negedge clk);
    start_i = 1'b1; x1_i = 1'b1; x2_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    repeat (W + 1) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk(result_o == 1'b0 && done_o == 1'b0, "R1 mid reset outputs", {result_o, done_o}, 0);
    chk(cell_wr_o == 0 && cell_clk_o == 0 && cell_rel_o == 0, "R1 mid reset strobes",
        {cell_wr_o, cell_clk_o, cell_rel_o}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    run_op(1'b1, 1'b1, 1'b0, 1'b0);
    run_op(1'b0, 1'b1, 1'b1, 1'b0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule